// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed BCD words and moves them forward by one second on each tick of an internal divider. The divider has two cascaded stages. A 7-bit first stage counts input clock cycles, and a 15-bit second stage counts the wraps of the first stage. The seconds tick therefore arrives every (A+1)·(S+1) input cycles.

Software drives the block through a small register front end. To change the calendar, it raises an init request and waits for the ready flag. While ready is set it may load the time, date and divider words. It then drops the request, and counting starts again from a cleared divider. A sticky flag records that this sequence has completed at least once since power-up, so firmware can skip reconfiguration on a warm restart. A format input chooses between 24-hour and 12-hour counting.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the time word is 0x000000, the date word is 0x002101 (day 01, month 01, weekday 1, year 00), the divider word is 0x7F00FF and the status word is 0x00.
- R2: Status bit 7 echoes the init request. Status bit 6 (ready) is set two clock edges after the request is first sampled high, and it clears one edge after the request is dropped.
- R3: Loads of the time, date and divider words take effect only while ready is set. A write at any other time leaves the stored word unchanged.
- R4: The divider word holds S in bits 14:0 and A in bits 22:16. Outside init mode the seconds tick is one cycle wide and repeats every (A+1)·(S+1) cycles. While the request or ready is high the calendar and the divider stay frozen. After the request is dropped, the first tick arrives (A+1)·(S+1) cycles after ready clears.
- R5: The time word holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. In 24-hour mode (format input 0), seconds and minutes wrap after 59 and hours wrap after 23 into the next day.
- R6: The date word holds BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year 00–99 (2000–2099) in bits 23:16. The day wraps to 01 after 30 in April, June, September and November. In February it wraps after 29 when the year is divisible by 4 and after 28 otherwise. In all other months it wraps after 31.
- R7: On each day wrap the weekday steps 1..7 and returns from 7 to 1. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R8: In 12-hour mode (format input 1), hours run 01..12 with bit 22 as the PM flag. 11 steps to 12 and toggles PM, 12 steps to 01, and 11:59:59 PM steps to 12:00:00 AM of the next day.
- R9: Status bit 4 sets when the block leaves init mode and stays set until reset.
- R10: All-zero time and date words are accepted as a load, and counting continues from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calendar input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Init mode request level |
| hour12 | input | 1 | Hour format: 0 selects 24-hour, 1 selects 12-hour |
| tr_we | input | 1 | Time word write strobe |
| tr_wd | input | 23 | Time word write data |
| dr_we | input | 1 | Date word write strobe |
| dr_wd | input | 24 | Date word write data |
| pr_we | input | 1 | Divider word write strobe |
| pr_wd | input | 23 | Divider word write data |
| tr_q | output | 23 | Current time word |
| dr_q | output | 24 | Current date word |
| pr_q | output | 23 | Current divider word |
| stat_q | output | 8 | Status: bit 7 request, bit 6 ready, bit 4 initialised |
| sec_tick | output | 1 | One-cycle seconds tick |

## Verification
The carry chain is tested by loading one instant just before each boundary and checking the value one tick later. The boundaries are a bare seconds step, a minute carry, and a midnight carry into each kind of month end. Three of the month ends are leap-year February, common-year February and a 30-day month. Two year-end cases are also loaded: one where the year steps by one, and 99 wrapping to 00. Together they separate a day wrap that is wrong for the month from a weekday or year carry that fails, and a leap test that reads the wrong digit. In 12-hour mode, the 11→12 PM flip, the 12→01 step and the PM-midnight day carry are told apart from the 24-hour wraps. Directed runs measure the handshake latency, the tick spacing and the first tick after release, and check that writes outside init mode are ignored.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic        hour12,
  input  logic        tr_we,
  input  logic [22:0] tr_wd,
  input  logic        dr_we,
  input  logic [23:0] dr_wd,
  input  logic        pr_we,
  input  logic [22:0] pr_wd,
  output logic [22:0] tr_q,
  output logic [23:0] dr_q,
  output logic [22:0] pr_q,
  output logic [7:0]  stat_q,
  output logic        sec_tick
);

  localparam logic [22:0] TR_MASK  = 23'h7F7F7F;
  localparam logic [23:0] DR_MASK  = 24'hFFFF3F;
  localparam logic [22:0] PR_MASK  = 23'h7F7FFF;
  localparam logic [23:0] DR_RESET = 24'h002101;
  localparam logic [22:0] PR_RESET = 23'h7F00FF;

  logic [1:0]  rdy_sr;
  logic        inited;
  logic [6:0]  cnt_a;
  logic [14:0] cnt_s;
  logic [22:0] t_nx;
  logic [23:0] d_nx;

  wire init_rdy = rdy_sr[1];
  wire run      = !init_req && !init_rdy;
  wire a_end    = cnt_a == pr_q[22:16];
  wire s_end    = cnt_s == pr_q[14:0];

  assign sec_tick = run && a_end && s_end;
  assign stat_q   = {init_req, init_rdy, 1'b0, inited, 4'b0000};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec_i, min_i, hr_i, day_i, mon_i, yr_i, last_day;
  logic       leap, day_carry;

  assign sec_i = bcd_inc({1'b0, tr_q[6:0]});
  assign min_i = bcd_inc({1'b0, tr_q[14:8]});
  assign hr_i  = bcd_inc({2'b00, tr_q[21:16]});
  assign day_i = bcd_inc({2'b00, dr_q[5:0]});
  assign mon_i = bcd_inc({3'b000, dr_q[12:8]});
  assign yr_i  = bcd_inc(dr_q[23:16]);
  assign leap  = (({dr_q[20], 1'b0} + dr_q[17:16]) == 2'b00);

  always_comb begin
    case (dr_q[12:8])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    t_nx = tr_q;
    d_nx = dr_q;
    day_carry = 1'b0;
    t_nx[6:0] = (tr_q[6:0] == 7'h59) ? 7'h00 : sec_i[6:0];
    if (tr_q[6:0] == 7'h59) begin
      t_nx[14:8] = (tr_q[14:8] == 7'h59) ? 7'h00 : min_i[6:0];
      if (tr_q[14:8] == 7'h59) begin
        if (!hour12) begin
          if (tr_q[21:16] == 6'h23) begin
            t_nx[21:16] = 6'h00;
            day_carry = 1'b1;
          end else t_nx[21:16] = hr_i[5:0];
        end else if (tr_q[21:16] == 6'h12) begin
          t_nx[21:16] = 6'h01;
        end else if (tr_q[21:16] == 6'h11) begin
          t_nx[21:16] = 6'h12;
          t_nx[22] = !tr_q[22];
          day_carry = tr_q[22];
        end else t_nx[21:16] = hr_i[5:0];
      end
    end
    if (day_carry) begin
      d_nx[15:13] = (dr_q[15:13] == 3'd7) ? 3'd1 : dr_q[15:13] + 3'd1;
      if (dr_q[5:0] == last_day[5:0]) begin
        d_nx[5:0] = 6'h01;
        if (dr_q[12:8] == 5'h12) begin
          d_nx[12:8]  = 5'h01;
          d_nx[23:16] = (dr_q[23:16] == 8'h99) ? 8'h00 : yr_i;
        end else d_nx[12:8] = mon_i[4:0];
      end else d_nx[5:0] = day_i[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_sr <= 2'b00;
      inited <= 1'b0;
      cnt_a  <= '0;
      cnt_s  <= '0;
      tr_q   <= '0;
      dr_q   <= DR_RESET;
      pr_q   <= PR_RESET;
    end else begin
      rdy_sr <= init_req ? {rdy_sr[0], 1'b1} : 2'b00;
      if (init_rdy && !init_req) inited <= 1'b1;
      if (!run) begin
        cnt_a <= '0;
        cnt_s <= '0;
      end else if (a_end) begin
        cnt_a <= '0;
        cnt_s <= s_end ? '0 : cnt_s + 15'd1;
      end else cnt_a <= cnt_a + 7'd1;
      if (init_rdy) begin
        if (tr_we) tr_q <= tr_wd & TR_MASK;
        if (dr_we) dr_q <= dr_wd & DR_MASK;
        if (pr_we) pr_q <= pr_wd & PR_MASK;
      end else if (sec_tick) begin
        tr_q <= t_nx;
        dr_q <= d_nx;
      end
    end
  end

  // R2
  ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_rdy) |-> init_req && $past(init_req));

  // R4
  frozen_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !tr_we) |=> $stable(tr_q));

  // R3
  prescale_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_rdy |=> $stable(pr_q));

  // R6
  date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(dr_we && init_rdy)) |=> $stable(dr_q));

  // R9
  inited_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[4] |=> stat_q[4]);

endmodule

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 1'b0, hour12 = 1'b0;
  logic tr_we = 1'b0, dr_we = 1'b0, pr_we = 1'b0;
  logic [22:0] tr_wd = '0, pr_wd = '0;
  logic [23:0] dr_wd = '0;
  logic [22:0] tr_q, pr_q;
  logic [23:0] dr_q;
  logic [7:0]  stat_q;
  logic        sec_tick;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_calendar_core uut (.clk, .rst_n, .init_req, .hour12, .tr_we, .tr_wd,
    .dr_we, .dr_wd, .pr_we, .pr_wd, .tr_q, .dr_q, .pr_q, .stat_q, .sec_tick);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic enter_init();
    @(negedge clk) init_req = 1'b1;
    for (int i = 0; i < 10 && !stat_q[6]; i++) @(negedge clk);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 100 && !sec_tick; i++) @(negedge clk);
  endtask

  task automatic load_run(input logic f, input logic [22:0] t, input logic [23:0] d);
    hour12 = f;
    enter_init();
    tr_we = 1'b1; tr_wd = t; dr_we = 1'b1; dr_wd = d;
    @(negedge clk);
    tr_we = 1'b0; dr_we = 1'b0; init_req = 1'b0;
    wait_tick();
    @(negedge clk);
  endtask

  // {format, time in, date in, time expected, date expected}
  localparam int NV = 15;
  localparam logic [94:0] VEC [0:NV-1] = '{
    {1'b0, 23'h000000, 24'h000000, 23'h000001, 24'h000000},
    {1'b0, 23'h123459, 24'h002101, 23'h123500, 24'h002101},
    {1'b0, 23'h090959, 24'h002101, 23'h091000, 24'h002101},
    {1'b0, 23'h235959, 24'h246228, 23'h000000, 24'h248229},
    {1'b0, 23'h235959, 24'h234228, 23'h000000, 24'h236301},
    {1'b0, 23'h235959, 24'h24E229, 23'h000000, 24'h242301},
    {1'b0, 23'h235959, 24'h002228, 23'h000000, 24'h004229},
    {1'b0, 23'h235959, 24'h21A430, 23'h000000, 24'h21C501},
    {1'b0, 23'h235959, 24'h99F231, 23'h000000, 24'h002101},
    {1'b0, 23'h235959, 24'h102131, 23'h000000, 24'h104201},
    {1'b0, 23'h235959, 24'h453231, 23'h000000, 24'h464101},
    {1'b1, 23'h115959, 24'h002101, 23'h520000, 24'h002101},
    {1'b1, 23'h525959, 24'h002101, 23'h410000, 24'h002101},
    {1'b1, 23'h515959, 24'h002101, 23'h120000, 24'h004102},
    {1'b1, 23'h125959, 24'h002101, 23'h010000, 24'h002101}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [22:0] held;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 time", tr_q, 23'h000000);
    chk("R1 date", dr_q, 24'h002101);
    chk("R1 divider", pr_q, 23'h7F00FF);
    chk("R1 status", stat_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 writes outside init are ignored
    tr_we = 1'b1; tr_wd = 23'h111111; pr_we = 1'b1; pr_wd = 23'h010002;
    @(negedge clk);
    tr_we = 1'b0; pr_we = 1'b0;
    chk("R3 time write ignored", tr_q, 23'h000000);
    chk("R3 divider write ignored", pr_q, 23'h7F00FF);
    // R2 handshake latency
    @(negedge clk) init_req = 1'b1;
    @(negedge clk);
    chk("R2 ready after one edge", stat_q, 8'h80);
    @(negedge clk);
    chk("R2 ready after two edges", stat_q, 8'hC0);
    pr_we = 1'b1; pr_wd = 23'h010002;
    @(negedge clk) pr_we = 1'b0;
    chk("R3 divider load in init", pr_q, 23'h010002);
    chk("R9 not yet initialised", stat_q[4], 1'b0);
    init_req = 1'b0;
    @(negedge clk);
    chk("R2 ready clears", stat_q, 8'h10);
    chk("R9 initialised after exit", stat_q[4], 1'b1);
    // R4 first tick and spacing, counted from ready clearing
    n = 1;
    while (!sec_tick && n < 50) begin @(negedge clk); n++; end
    chk("R4 first tick delay", n, 6);
    chk("R4 first step", tr_q, 23'h000000);
    @(negedge clk);
    chk("R4 step after tick", tr_q, 23'h000001);
    n = 1;
    while (!sec_tick && n < 50) begin @(negedge clk); n++; end
    chk("R4 tick spacing", n, 6);
    // R5 R6 R7 R8 R10 vector table
    for (int v = 0; v < NV; v++) begin
      load_run(VEC[v][94], VEC[v][93:71], VEC[v][70:47]);
      chk("R5/R8 time after tick", tr_q, VEC[v][46:24]);
      chk("R6/R7 date after tick", dr_q, VEC[v][23:0]);
    end
    // R10 zero load accepted
    hour12 = 1'b0;
    enter_init();
    tr_we = 1'b1; tr_wd = 23'h0; dr_we = 1'b1; dr_wd = 24'h0;
    @(negedge clk) tr_we = 1'b0; dr_we = 1'b0;
    chk("R10 zero time loaded", tr_q, 23'h0);
    chk("R10 zero date loaded", dr_q, 24'h0);
    // R4 frozen while in init
    held = tr_q;
    n = 0;
    repeat (30) begin @(negedge clk); if (sec_tick) n++; end
    chk("R4 no tick in init", n, 0);
    chk("R4 time frozen in init", tr_q, held);
    chk("R9 flag held in init", stat_q[4], 1'b1);
    // R3 writes after leaving init are ignored
    init_req = 1'b0;
    @(negedge clk);
    tr_we = 1'b1; tr_wd = 23'h222222;
    @(negedge clk) tr_we = 1'b0;
    chk("R3 write after exit ignored", tr_q, 23'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule